// File: doc/BRIEF.md
# Multi-link data concentrator

The concentrator sits between one host readout port and eight front-end links. In the downstream direction it copies configuration frames from the host onto the links. The first word of every frame carries a low and a high link bound. Every enabled link whose number lies inside that range receives the whole frame. The host therefore never has to address the links one at a time, and a single frame covering the full range reaches the entire set.

In the upstream direction each link writes its data frames into a private 16-entry FIFO. A round-robin arbiter then hands the host port to one link at a time, for one complete frame. Every merged frame opens with a tag word that holds the source link number.

A per-link enable mask takes dead links out of service. A disabled link receives no downstream words, and anything it sends upstream is drained and dropped, so it can stall neither direction.

Top module: `link_concentrator`

## Requirements
- R1: After reset, no downstream link valid and no host upstream valid is asserted, and every link's upstream ready is high while its FIFO is empty.
- R2: The first word of a configuration frame holds the low bound in bits [2:0] and the high bound in bits [5:3]. Every word of that frame goes to exactly those enabled links i with low ≤ i ≤ high.
- R3: A frame with low=0 and high=7 reaches every enabled link.
- R4: The host-side configuration ready stays low until every targeted link has accepted the current word. Each targeted link takes each word exactly once.
- R5: A link whose enable bit is 0 receives no downstream word. Its upstream ready is held high, and its upstream words are discarded and never reach the host.
- R6: Each enabled link buffers up to 16 upstream words. Its upstream ready drops once 16 words are held and none has been read out.
- R7: Each merged upstream frame is a tag word followed by the link's payload words in arrival order. The tag word has the source link number in bits [2:0], zero in all other bits, and last low. Last is set only on the final payload word.
- R8: After a frame from link k completes, the next grant goes to the first link after k, wrapping around, whose FIFO is non-empty and which is enabled.
- R9: Words of different frames never interleave on the host upstream port.
- R10: A configuration frame whose range selects no enabled link (including low > high) is consumed without stalling, and no link sees it.
- R11: While the host upstream valid is high and its ready is low, valid, data and last stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| link_en_i | input | 8 | Per-link enable mask |
| cfg_valid_i | input | 1 | Host configuration word valid |
| cfg_data_i | input | 16 | Host configuration word |
| cfg_last_i | input | 1 | Last word of configuration frame |
| cfg_ready_o | output | 1 | Configuration word accepted by all targets |
| lnk_dn_valid_o | output | 8 | Per-link downstream valid |
| lnk_dn_data_o | output | 16 | Downstream word, shared by all links |
| lnk_dn_last_o | output | 1 | Downstream last word |
| lnk_dn_ready_i | input | 8 | Per-link downstream ready |
| lnk_up_valid_i | input | 8 | Per-link upstream valid |
| lnk_up_data_i | input | 128 | Per-link upstream words, link i at bits [16i+15:16i] |
| lnk_up_last_i | input | 8 | Per-link upstream last |
| lnk_up_ready_o | output | 8 | Per-link upstream ready |
| rd_valid_o | output | 1 | Merged upstream valid |
| rd_data_o | output | 16 | Merged upstream word |
| rd_last_o | output | 1 | Merged upstream last |
| rd_ready_i | input | 1 | Host upstream ready |

## Verification
The bench uses the default parameters: eight links, 16-bit words and 16-entry FIFOs. With these values all 64 low/high pairs can be swept under three enable masks, which covers full broadcast, single links, partial ranges and empty ranges, while link readiness is staggered per link. The 16-entry depth lets one link fill its FIFO to the stall point with a single 20-word frame. With eight links, a wrap-around grant order can be forced from just three requesters.

// File: rtl/lc_pkg.sv
package lc_pkg;
  typedef enum logic [1:0] {M_IDLE, M_HDR, M_BODY} merge_state_e;
endpackage

// File: rtl/lc_fifo.sv
module lc_fifo #(
  parameter int W     = 17,
  parameter int DEPTH = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;

  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign rdata_o = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (pop_i)  rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + (AW+1)'(push_i) - (AW+1)'(pop_i);
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_no_underflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/lc_bcast.sv
module lc_bcast #(
  parameter int N  = 8,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  link_en_i,
  input  logic          h_valid_i,
  input  logic [DW-1:0] h_data_i,
  input  logic          h_last_i,
  output logic          h_ready_o,
  output logic [N-1:0]  d_valid_o,
  output logic [DW-1:0] d_data_o,
  output logic          d_last_o,
  input  logic [N-1:0]  d_ready_i
);
  localparam int TW = $clog2(N);

  logic          in_frame_q;
  logic [N-1:0]  tgt_q, done_q, tgt_hdr, tgt;
  logic [TW-1:0] lo, hi;

  assign lo = h_data_i[TW-1:0];
  assign hi = h_data_i[2*TW-1:TW];

  always_comb begin
    for (int i = 0; i < N; i++)
      tgt_hdr[i] = (TW'(i) >= lo) && (TW'(i) <= hi);
  end

  // bound decode only on the first word; later words reuse the latched set
  assign tgt       = (in_frame_q ? tgt_q : tgt_hdr) & link_en_i;
  assign d_valid_o = {N{h_valid_i}} & tgt & ~done_q;
  assign d_data_o  = h_data_i;
  assign d_last_o  = h_last_i;
  assign h_ready_o = &(~tgt | done_q | d_ready_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      tgt_q      <= '0;
      done_q     <= '0;
    end else if (h_valid_i && h_ready_o) begin
      done_q     <= '0;
      in_frame_q <= !h_last_i;
      if (!in_frame_q) tgt_q <= tgt_hdr;
    end else begin
      done_q <= done_q | (d_valid_o & d_ready_i);
    end
  end

  assert_once_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_valid_i && !h_ready_o) |=> ((d_valid_o & $past(d_valid_o & d_ready_i)) == '0));
endmodule

// File: rtl/lc_merge.sv
module lc_merge
  import lc_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N-1:0]    link_en_i,
  input  logic [N-1:0]    nempty_i,
  input  logic [N*DW-1:0] head_data_i,
  input  logic [N-1:0]    head_last_i,
  output logic [N-1:0]    pop_o,
  output logic            valid_o,
  output logic [DW-1:0]   data_o,
  output logic            last_o,
  input  logic            ready_i
);
  localparam int TW = $clog2(N);

  merge_state_e  state_q;
  logic [TW-1:0] grant_q, pick;
  logic [N-1:0]  req;
  logic          found;

  assign req = nempty_i & link_en_i;

  always_comb begin
    found = 1'b0;
    pick  = grant_q;
    for (int k = 1; k <= N; k++) begin
      int unsigned j;
      j = (int'(grant_q) + k) % N;
      if (!found && req[j]) begin
        found = 1'b1;
        pick  = TW'(j);
      end
    end
  end

  always_comb begin
    valid_o = 1'b0;
    data_o  = '0;
    last_o  = 1'b0;
    pop_o   = '0;
    case (state_q)
      M_HDR: begin
        valid_o = 1'b1;
        data_o  = {{(DW-TW){1'b0}}, grant_q};
      end
      M_BODY: begin
        valid_o = nempty_i[grant_q];
        data_o  = head_data_i[grant_q*DW +: DW];
        last_o  = head_last_i[grant_q];
        pop_o[grant_q] = valid_o && ready_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= M_IDLE;
      grant_q <= TW'(N-1);
    end else begin
      case (state_q)
        M_IDLE: if (found) begin
          grant_q <= pick;
          state_q <= M_HDR;
        end
        M_HDR:  if (ready_i) state_q <= M_BODY;
        M_BODY: if (valid_o && ready_i && last_o) state_q <= M_IDLE;
        default: state_q <= M_IDLE;
      endcase
    end
  end

  assert_grant_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == M_IDLE && |req) |=> (state_q == M_HDR && nempty_i[grant_q]));
  assert_no_interleave_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == M_BODY && !(valid_o && ready_i && last_o)) |=>
      (state_q == M_BODY && grant_q == $past(grant_q)));
  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o) && $stable(last_o)));
endmodule

// File: rtl/link_concentrator.sv
module link_concentrator #(
  parameter int N     = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N-1:0]    link_en_i,
  input  logic            cfg_valid_i,
  input  logic [DW-1:0]   cfg_data_i,
  input  logic            cfg_last_i,
  output logic            cfg_ready_o,
  output logic [N-1:0]    lnk_dn_valid_o,
  output logic [DW-1:0]   lnk_dn_data_o,
  output logic            lnk_dn_last_o,
  input  logic [N-1:0]    lnk_dn_ready_i,
  input  logic [N-1:0]    lnk_up_valid_i,
  input  logic [N*DW-1:0] lnk_up_data_i,
  input  logic [N-1:0]    lnk_up_last_i,
  output logic [N-1:0]    lnk_up_ready_o,
  output logic            rd_valid_o,
  output logic [DW-1:0]   rd_data_o,
  output logic            rd_last_o,
  input  logic            rd_ready_i
);
  logic [N-1:0]    full, empty, push, pop, head_last;
  logic [N*DW-1:0] head_data;

  lc_bcast #(.N(N), .DW(DW)) u_bcast (
    .clk_i, .rst_ni, .link_en_i,
    .h_valid_i (cfg_valid_i),
    .h_data_i  (cfg_data_i),
    .h_last_i  (cfg_last_i),
    .h_ready_o (cfg_ready_o),
    .d_valid_o (lnk_dn_valid_o),
    .d_data_o  (lnk_dn_data_o),
    .d_last_o  (lnk_dn_last_o),
    .d_ready_i (lnk_dn_ready_i)
  );

  for (genvar i = 0; i < N; i++) begin : g_link
    // disabled link: always ready, words dropped
    assign lnk_up_ready_o[i] = !link_en_i[i] || !full[i];
    assign push[i] = lnk_up_valid_i[i] && link_en_i[i] && !full[i];

    lc_fifo #(.W(DW+1), .DEPTH(DEPTH)) u_fifo (
      .clk_i, .rst_ni,
      .push_i  (push[i]),
      .wdata_i ({lnk_up_last_i[i], lnk_up_data_i[i*DW +: DW]}),
      .pop_i   (pop[i]),
      .rdata_o ({head_last[i], head_data[i*DW +: DW]}),
      .full_o  (full[i]),
      .empty_o (empty[i])
    );
  end

  lc_merge #(.N(N), .DW(DW)) u_merge (
    .clk_i, .rst_ni, .link_en_i,
    .nempty_i    (~empty),
    .head_data_i (head_data),
    .head_last_i (head_last),
    .pop_o       (pop),
    .valid_o     (rd_valid_o),
    .data_o      (rd_data_o),
    .last_o      (rd_last_o),
    .ready_i     (rd_ready_i)
  );
endmodule

// File: tb/link_concentrator_tb.sv
module link_concentrator_tb;
  logic         clk = 1'b0;
  logic         rst_ni;
  logic [7:0]   link_en;
  logic         cfg_valid, cfg_last, cfg_ready;
  logic [15:0]  cfg_data;
  logic [7:0]   dn_valid, dn_ready;
  logic [15:0]  dn_data;
  logic         dn_last;
  logic [7:0]   up_valid, up_last, up_ready;
  logic [127:0] up_data;
  logic         rd_valid, rd_last, rd_ready;
  logic [15:0]  rd_data;

  always #4 clk = ~clk;

  link_concentrator u_dut (
    .clk_i(clk), .rst_ni, .link_en_i(link_en),
    .cfg_valid_i(cfg_valid), .cfg_data_i(cfg_data), .cfg_last_i(cfg_last), .cfg_ready_o(cfg_ready),
    .lnk_dn_valid_o(dn_valid), .lnk_dn_data_o(dn_data), .lnk_dn_last_o(dn_last), .lnk_dn_ready_i(dn_ready),
    .lnk_up_valid_i(up_valid), .lnk_up_data_i(up_data), .lnk_up_last_i(up_last), .lnk_up_ready_o(up_ready),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .rd_last_o(rd_last), .rd_ready_i(rd_ready)
  );

  int n_chk = 0, n_err = 0;
  int cyc = 0;
  bit rd_go = 1'b0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // link readiness and host readiness patterns
  initial begin
    dn_ready = '0;
    rd_ready = 1'b0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      for (int i = 0; i < 8; i++) dn_ready[i] = ((cyc + i) % 3) != 0;
      rd_ready = rd_go && (cyc % 4 != 3);
    end
  end

  // downstream monitor
  int dn_cnt[8], dn_sum[8], dn_lst[8];
  int r4_err;
  always @(negedge clk) begin
    if (rst_ni) begin
      for (int i = 0; i < 8; i++)
        if (dn_valid[i] && dn_ready[i]) begin
          dn_cnt[i]++;
          dn_sum[i] += int'(dn_data);
          if (dn_last) dn_lst[i]++;
        end
      if (cfg_valid && cfg_ready && |(dn_valid & ~dn_ready)) r4_err++;
    end
  end

  // upstream monitor
  int rx_n = 0;
  int rx_tag[32], rx_len[32];
  bit exp_hdr = 1'b1;
  int cur_tag, widx, cur_len;
  bit pv = 1'b0, pr = 1'b0, pl = 1'b0;
  logic [15:0] pd = '0;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (pv && !pr)
        chk(rd_valid && rd_data == pd && rd_last == pl, "R11", int'(rd_data), int'(pd));
      if (rd_valid && rd_ready) begin
        if (exp_hdr) begin
          chk(rd_data[15:3] == 0 && !rd_last, "R7", int'(rd_data), int'(rd_data[2:0]));
          cur_tag = int'(rd_data[2:0]);
          rx_tag[rx_n] = cur_tag;
          rx_n++;
          widx = 0;
          exp_hdr = 1'b0;
        end else begin
          cur_len = int'(rd_data[12:8]);
          chk(int'(rd_data[15:13]) == cur_tag, "R9", int'(rd_data[15:13]), cur_tag);
          chk(int'(rd_data[7:0]) == widx, "R7", int'(rd_data[7:0]), widx);
          chk(rd_last == (widx == cur_len - 1), "R7", int'(rd_last), int'(widx == cur_len - 1));
          widx++;
          rx_len[rx_n-1] = widx;
          if (rd_last) exp_hdr = 1'b1;
        end
      end
    end
    pv = rd_valid; pr = rd_ready; pd = rd_data; pl = rd_last;
  end

  task automatic send_cfg(int lo, int hi, int plen, int fno);
    for (int w = 0; w <= plen; w++) begin
      cfg_data  = (w == 0) ? 16'((hi << 3) | lo) : 16'(16'h8000 + fno * 8 + w);
      cfg_last  = (w == plen);
      cfg_valid = 1'b1;
      do @(negedge clk); while (!cfg_ready);
      @(posedge clk); #1;
    end
    cfg_valid = 1'b0;
    cfg_last  = 1'b0;
  endtask

  task automatic push(int l, int len, int w);
    up_valid[l] = 1'b1;
    up_data[l*16 +: 16] = 16'((l << 13) | (len << 8) | w);
    up_last[l] = (w == len - 1);
    do @(negedge clk); while (!up_ready[l]);
    @(posedge clk); #1;
    up_valid[l] = 1'b0;
  endtask

  task automatic push_frame(int l, int len);
    for (int w = 0; w < len; w++) push(l, len, w);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] masks [3];
    int fno;
    masks[0] = 8'hFF; masks[1] = 8'hA5; masks[2] = 8'h3C;
    rst_ni = 1'b0; link_en = 8'hFF;
    cfg_valid = 1'b0; cfg_data = '0; cfg_last = 1'b0;
    up_valid = '0; up_data = '0; up_last = '0;
    repeat (3) @(posedge clk); #1;
    rst_ni = 1'b1;
    @(negedge clk);
    chk(rd_valid == 1'b0, "R1", int'(rd_valid), 0);
    chk(dn_valid == '0, "R1", int'(dn_valid), 0);
    chk(up_ready == 8'hFF, "R1", int'(up_ready), 255);
    @(posedge clk); #1;

    // downstream sweep: every bound pair under three masks
    fno = 0;
    for (int m = 0; m < 3; m++) begin
      link_en = masks[m];
      for (int lo = 0; lo < 8; lo++)
        for (int hi = 0; hi < 8; hi++) begin
          int plen;
          plen = 1 + (fno % 3);
          for (int i = 0; i < 8; i++) begin dn_cnt[i] = 0; dn_sum[i] = 0; dn_lst[i] = 0; end
          r4_err = 0;
          send_cfg(lo, hi, plen, fno);
          chk(r4_err == 0, "R4", r4_err, 0);
          for (int i = 0; i < 8; i++) begin
            bit hit;
            int esum;
            string tag;
            hit = masks[m][i] && lo <= i && i <= hi;
            esum = (hi << 3) | lo;
            for (int w = 1; w <= plen; w++) esum += 16'h8000 + fno * 8 + w;
            tag = (lo == 0 && hi == 7) ? "R3" : (!masks[m][i] ? "R5" : (lo > hi ? "R10" : "R2"));
            chk(dn_cnt[i] == (hit ? plen + 1 : 0), tag, dn_cnt[i], hit ? plen + 1 : 0);
            chk(dn_sum[i] == (hit ? esum : 0), "R4", dn_sum[i], hit ? esum : 0);
            chk(dn_lst[i] == int'(hit), tag, dn_lst[i], int'(hit));
          end
          fno++;
        end
    end

    // upstream: ascending grants, disabled link drained
    link_en = 8'hA5; rd_go = 1'b0; rx_n = 0;
    push_frame(0, 1); push_frame(2, 3); push_frame(5, 3); push_frame(7, 2);
    for (int w = 0; w < 3; w++) begin
      chk(up_ready[1] == 1'b1, "R5", int'(up_ready[1]), 1);
      push(1, 3, w);
    end
    rd_go = 1'b1;
    repeat (200) @(posedge clk); #1;
    chk(rx_n == 4, "R8", rx_n, 4);
    chk(rx_tag[0] == 0, "R8", rx_tag[0], 0);
    chk(rx_tag[1] == 2, "R8", rx_tag[1], 2);
    chk(rx_tag[2] == 5, "R8", rx_tag[2], 5);
    chk(rx_tag[3] == 7, "R5", rx_tag[3], 7);

    // wrap-around: after link 5, link 0 comes after 2 and 5
    rd_go = 1'b0; rx_n = 0;
    push_frame(2, 2); push_frame(5, 1); push_frame(0, 3);
    rd_go = 1'b1;
    repeat (200) @(posedge clk); #1;
    chk(rx_n == 3, "R8", rx_n, 3);
    chk(rx_tag[0] == 2, "R8", rx_tag[0], 2);
    chk(rx_tag[1] == 5, "R8", rx_tag[1], 5);
    chk(rx_tag[2] == 0, "R8", rx_tag[2], 0);

    // FIFO depth: 16 words accepted, then stall
    link_en = 8'hFF; rd_go = 1'b0; rx_n = 0;
    for (int w = 0; w < 16; w++) begin
      chk(up_ready[3] == 1'b1, "R6", int'(up_ready[3]), 1);
      push(3, 20, w);
    end
    up_valid[3] = 1'b1;
    up_data[3*16 +: 16] = 16'((3 << 13) | (20 << 8) | 16);
    up_last[3] = 1'b0;
    repeat (5) @(negedge clk);
    chk(up_ready[3] == 1'b0, "R6", int'(up_ready[3]), 0);
    @(posedge clk); #1;
    rd_go = 1'b1;
    for (int w = 16; w < 20; w++) push(3, 20, w);
    repeat (300) @(posedge clk); #1;
    chk(rx_n == 1, "R6", rx_n, 1);
    chk(rx_tag[0] == 3, "R7", rx_tag[0], 3);
    chk(rx_len[0] == 20, "R6", rx_len[0], 20);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule